// File: doc/BRIEF.md
# QoS Prioritized Channel Access Engine

The engine arbitrates a wireless station's transmitter among four traffic classes: background, best effort, video and voice, in rising priority. Each incoming frame descriptor carries a 3-bit user priority. The engine maps that priority to a class and appends the descriptor to that class's own queue. Each class then runs its own contention function. That function waits for the medium to stay idle for a class-specific interval, counts down a random backoff in slots, and bids for the transmitter.

A winning class holds a transmit opportunity. The engine shows the class, the head descriptor, and the ticks left in the opportunity. The external frame sequencer reports each exchange as a success or a failure. On a success the class may send further frames while its opportunity lasts. On a failure the class widens its contention window and contends again with the same frame. All timing is counted in ticks of `tick_i`. The slot length, the SIFS length and the opportunity limits are programmable tick counts.

Top module: `qos_access_engine`

## Requirements
- R1: A descriptor pushed with `enq_valid_i` is queued in a class chosen by `enq_prio_i`. Priorities 1 and 2 go to class 0 (background). Priorities 0 and 3 go to class 1 (best effort). Priorities 4 and 5 go to class 2 (video). Priorities 6 and 7 go to class 3 (voice). `grant_ac_o` reports the class with this same coding.
- R2: The idle wait of class k is T = aifsn·slot_len + sifs_len ticks. The AIFSN of class k sits in `aifsn_i[4k+3:4k]`. A class with zero backoff is granted on the clock after T consecutive idle ticks. With `tick_i` held high, that is T+1 cycles after `medium_idle_i` rises. Without ticks, no time passes.
- R3: Whenever the medium is busy, the idle wait restarts from zero and the backoff counter holds its value. Counting resumes only after a complete new idle wait.
- R4: When several classes become ready in the same cycle, the highest-numbered class is granted. Every other ready class widens its window as after a failure and draws a new backoff.
- R5: Each class queue is first-in first-out. `grant_desc_o` shows the head descriptor of the granted class.
- R6: With an opportunity limit of zero, a grant covers exactly one exchange. The grant ends on the clock after `tx_done_i`.
- R7: At grant, `txop_left_o` loads the class limit from `txop_lim_i[16k+15:16k]`. It then drops by one per tick, stops at zero, and reads zero while no grant is held. The granted class stays fixed for the whole grant.
- R8: On a successful exchange (`tx_done_i` with `tx_ok_i`=1), the head frame leaves the queue. The grant continues only if `txop_left_o` is nonzero and another frame is queued in that class. Otherwise the grant ends.
- R9: A failed exchange (`tx_ok_i`=0) ends the grant and keeps the frame queued. The window becomes 2·CW+1, capped at the class maximum. Every new backoff is a value from 0 to CW inclusive, in slots.
- R10: A successful exchange returns the class window to its minimum.
- R11: Background and best effort use the base window limits `cw_min_i`/`cw_max_i`. Video uses (cw_min+1)/2−1 up to cw_min. Voice uses (cw_min+1)/4−1 up to (cw_min+1)/2−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| medium_idle_i | input | 1 | Carrier sense reports an idle medium |
| tick_i | input | 1 | Time base pulse, one tick |
| slot_len_i | input | TICK_W | Slot length in ticks |
| sifs_len_i | input | TICK_W | SIFS length in ticks |
| aifsn_i | input | 4·AIFSN_W | Per-class AIFSN, class k at field k |
| cw_min_i | input | CW_W | Base minimum contention window |
| cw_max_i | input | CW_W | Base maximum contention window |
| txop_lim_i | input | 4·TICK_W | Per-class opportunity limit in ticks, class k at field k |
| enq_valid_i | input | 1 | Push a descriptor |
| enq_prio_i | input | 3 | User priority of the pushed descriptor |
| enq_desc_i | input | DESC_W | Descriptor to push |
| tx_done_i | input | 1 | Current exchange finished |
| tx_ok_i | input | 1 | Exchange result, 1 = success |
| grant_o | output | 1 | A transmit opportunity is held |
| grant_ac_o | output | 2 | Granted class |
| grant_desc_o | output | DESC_W | Head descriptor of the granted class |
| txop_left_o | output | TICK_W | Ticks remaining in the opportunity |

## Verification
The bench programs windows of zero width, so the grant cycle can be predicted exactly. It measures that cycle against the idle-wait formula for short and long classes. An idle wait cut short by a busy medium must restart from zero; a design that resumes the count grants too early. Video and voice become ready in the same cycle, so a wrong priority order shows up as the wrong class on the first grant. The opportunity tests cover continuation, tick countdown, stopping at zero, and the end of a grant when the limit runs out with frames still queued. A failure case checks that the frame is kept; a design that drops it would show the next descriptor instead. Range checks on grant delay catch windows that never saturate. They also catch derived video and voice windows taken from the wrong formula.

// File: rtl/qae_pkg.sv
package qae_pkg;
  typedef enum logic [1:0] {
    AC_BK = 2'd0,
    AC_BE = 2'd1,
    AC_VI = 2'd2,
    AC_VO = 2'd3
  } ac_e;

  function automatic ac_e prio_to_ac(input logic [2:0] prio);
    case (prio)
      3'd1, 3'd2: return AC_BK;
      3'd0, 3'd3: return AC_BE;
      3'd4, 3'd5: return AC_VI;
      default:    return AC_VO;
    endcase
  endfunction
endpackage

// File: rtl/qae_fifo.sv
module qae_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         nonempty_o,
  output logic         multi_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign do_pop  = pop_i && (cnt != '0);
  assign do_push = push_i && (cnt != CNT_W'(DEPTH));

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  assign head_o     = mem[rd_ptr];
  assign nonempty_o = (cnt != '0);
  assign multi_o    = (cnt > CNT_W'(1));

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
  a_r5_pop_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt != '0));
endmodule

// File: rtl/qae_lfsr.sv
module qae_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED;
    else         state_o <= state_o[0] ? ((state_o >> 1) ^ TAPS) : (state_o >> 1);
  end

  a_r9_lfsr_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0);
endmodule

// File: rtl/qae_ac_engine.sv
module qae_ac_engine #(
  parameter int TICK_W  = 16,
  parameter int CW_W    = 10,
  parameter int AIFSN_W = 4,
  parameter int DESC_W  = 8,
  parameter int QDEPTH  = 4,
  parameter int RND_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               medium_idle_i,
  input  logic               busy_i,
  input  logic [TICK_W-1:0]  slot_len_i,
  input  logic [TICK_W-1:0]  sifs_len_i,
  input  logic [AIFSN_W-1:0] aifsn_i,
  input  logic [CW_W-1:0]    cw_lo_i,
  input  logic [CW_W-1:0]    cw_hi_i,
  input  logic [RND_W-1:0]   rnd_i,
  input  logic               enq_i,
  input  logic [DESC_W-1:0]  desc_i,
  input  logic               won_i,
  input  logic               grow_i,
  input  logic               pop_i,
  input  logic               reset_cw_i,
  output logic               ready_o,
  output logic [DESC_W-1:0]  head_o,
  output logic               more_o
);
  localparam int AIFS_W = TICK_W + AIFSN_W + 1;
  localparam int STG_W  = $clog2(CW_W + 1);
  localparam int GW     = 2 * CW_W + 1;

  logic              nonempty;
  logic [AIFS_W-1:0] aifs_cnt, aifs_target;
  logic              aifs_done;
  logic [TICK_W-1:0] slot_cnt;
  logic              slot_last, slot_end;
  logic [STG_W-1:0]  stage;
  logic [GW-1:0]     grown;
  logic [CW_W-1:0]   cw;
  logic [CW_W-1:0]   bo;
  logic              bo_vld;

  qae_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) i_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (enq_i),
    .data_i     (desc_i),
    .pop_i      (pop_i),
    .head_o     (head_o),
    .nonempty_o (nonempty),
    .multi_o    (more_o)
  );

  // Contention window: ((lo+1) << stage) - 1, capped at hi
  assign grown = ((GW'(cw_lo_i) + GW'(1)) << stage) - GW'(1);
  assign cw    = (grown >= GW'(cw_hi_i)) ? cw_hi_i : grown[CW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage <= '0;
    else if (reset_cw_i) stage <= '0;
    else if (grow_i && (grown < GW'(cw_hi_i)) && (stage < STG_W'(CW_W)))
      stage <= stage + STG_W'(1);
  end

  // Idle wait
  assign aifs_target = AIFS_W'(aifsn_i) * AIFS_W'(slot_len_i) + AIFS_W'(sifs_len_i);
  assign aifs_done   = medium_idle_i && !busy_i && (aifs_cnt >= aifs_target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) aifs_cnt <= '0;
    else if (!medium_idle_i || busy_i) aifs_cnt <= '0;
    else if (tick_i && (aifs_cnt < aifs_target)) aifs_cnt <= aifs_cnt + AIFS_W'(1);
  end

  // Slot boundaries after the idle wait
  assign slot_last = ({1'b0, slot_cnt} + (TICK_W + 1)'(1)) >= {1'b0, slot_len_i};
  assign slot_end  = aifs_done && tick_i && slot_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_cnt <= '0;
    else if (!aifs_done) slot_cnt <= '0;
    else if (tick_i) slot_cnt <= slot_last ? '0 : slot_cnt + TICK_W'(1);
  end

  // Backoff counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bo     <= '0;
      bo_vld <= 1'b0;
    end else if (won_i || grow_i) begin
      bo_vld <= 1'b0;
    end else if (!bo_vld && nonempty && !busy_i) begin
      bo     <= CW_W'(rnd_i & RND_W'(cw));
      bo_vld <= 1'b1;
    end else if (bo_vld && (bo != '0) && slot_end) begin
      bo <= bo - CW_W'(1);
    end
  end

  assign ready_o = bo_vld && (bo == '0) && aifs_done && nonempty;

  a_r3_freeze_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!medium_idle_i && bo_vld) |=> $stable(bo));
  a_r2_hold_during_aifs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_vld && !aifs_done) |=> $stable(bo));
  a_r9_draw_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bo_vld) |-> (bo <= cw));
endmodule

// File: rtl/qos_access_engine.sv
module qos_access_engine
  import qae_pkg::*;
#(
  parameter int TICK_W  = 16,
  parameter int CW_W    = 10,
  parameter int AIFSN_W = 4,
  parameter int DESC_W  = 8,
  parameter int QDEPTH  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 medium_idle_i,
  input  logic                 tick_i,
  input  logic [TICK_W-1:0]    slot_len_i,
  input  logic [TICK_W-1:0]    sifs_len_i,
  input  logic [4*AIFSN_W-1:0] aifsn_i,
  input  logic [CW_W-1:0]      cw_min_i,
  input  logic [CW_W-1:0]      cw_max_i,
  input  logic [4*TICK_W-1:0]  txop_lim_i,
  input  logic                 enq_valid_i,
  input  logic [2:0]           enq_prio_i,
  input  logic [DESC_W-1:0]    enq_desc_i,
  input  logic                 tx_done_i,
  input  logic                 tx_ok_i,
  output logic                 grant_o,
  output logic [1:0]           grant_ac_o,
  output logic [DESC_W-1:0]    grant_desc_o,
  output logic [TICK_W-1:0]    txop_left_o
);
  localparam int NUM_AC = 4;
  localparam int RND_W  = 16;

  logic [RND_W-1:0]  lfsr;
  logic [NUM_AC-1:0] ready_vec, more_vec, won_vec, grow_vec, pop_vec, enq_vec;
  logic [DESC_W-1:0] head [NUM_AC];
  logic [CW_W:0]     lo_p1;
  logic              busy, start, fin_ok, fin_bad;
  ac_e               cur_ac, win_ac;
  logic [TICK_W-1:0] txop_left;

  qae_lfsr #(.W(RND_W)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr)
  );

  assign lo_p1   = {1'b0, cw_min_i} + (CW_W + 1)'(1);
  assign start   = !busy && (ready_vec != '0);
  assign fin_ok  = busy && tx_done_i && tx_ok_i;
  assign fin_bad = busy && tx_done_i && !tx_ok_i;

  always_comb begin
    win_ac = AC_BK;
    for (int k = 0; k < NUM_AC; k++)
      if (ready_vec[k]) win_ac = ac_e'(k);
  end

  always_comb begin
    won_vec  = '0;
    grow_vec = '0;
    pop_vec  = '0;
    enq_vec  = '0;
    if (start) begin
      won_vec[win_ac] = 1'b1;
      grow_vec        = ready_vec & ~won_vec;
    end
    if (fin_bad) grow_vec[cur_ac] = 1'b1;
    if (fin_ok)  pop_vec[cur_ac]  = 1'b1;
    if (enq_valid_i) enq_vec[prio_to_ac(enq_prio_i)] = 1'b1;
  end

  for (genvar k = 0; k < NUM_AC; k++) begin : g_ac
    logic [CW_W-1:0] lo, hi;
    if (k == int'(AC_VO)) begin : g_vo
      assign lo = ((lo_p1 >> 2) == '0) ? '0 : CW_W'((lo_p1 >> 2) - (CW_W + 1)'(1));
      assign hi = ((lo_p1 >> 1) == '0) ? '0 : CW_W'((lo_p1 >> 1) - (CW_W + 1)'(1));
    end else if (k == int'(AC_VI)) begin : g_vi
      assign lo = ((lo_p1 >> 1) == '0) ? '0 : CW_W'((lo_p1 >> 1) - (CW_W + 1)'(1));
      assign hi = cw_min_i;
    end else begin : g_base
      assign lo = cw_min_i;
      assign hi = cw_max_i;
    end

    qae_ac_engine #(
      .TICK_W (TICK_W), .CW_W (CW_W), .AIFSN_W (AIFSN_W),
      .DESC_W (DESC_W), .QDEPTH (QDEPTH), .RND_W (RND_W)
    ) i_engine (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick_i),
      .medium_idle_i (medium_idle_i),
      .busy_i        (busy),
      .slot_len_i    (slot_len_i),
      .sifs_len_i    (sifs_len_i),
      .aifsn_i       (aifsn_i[k*AIFSN_W +: AIFSN_W]),
      .cw_lo_i       (lo),
      .cw_hi_i       (hi),
      .rnd_i         (RND_W'({lfsr, lfsr} >> (3 * k))),
      .enq_i         (enq_vec[k]),
      .desc_i        (enq_desc_i),
      .won_i         (won_vec[k]),
      .grow_i        (grow_vec[k]),
      .pop_i         (pop_vec[k]),
      .reset_cw_i    (pop_vec[k]),
      .ready_o       (ready_vec[k]),
      .head_o        (head[k]),
      .more_o        (more_vec[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy      <= 1'b0;
      cur_ac    <= AC_BK;
      txop_left <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      cur_ac    <= win_ac;
      txop_left <= txop_lim_i[int'(win_ac)*TICK_W +: TICK_W];
    end else if (busy) begin
      if (fin_bad) busy <= 1'b0;
      else if (fin_ok && ((txop_left == '0) || !more_vec[cur_ac])) busy <= 1'b0;
      if (tick_i && (txop_left != '0)) txop_left <= txop_left - TICK_W'(1);
    end
  end

  assign grant_o      = busy;
  assign grant_ac_o   = cur_ac;
  assign grant_desc_o = busy ? head[cur_ac] : '0;
  assign txop_left_o  = busy ? txop_left : '0;

  a_r4_highest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (($past(ready_vec) >> cur_ac) == NUM_AC'(1)));
  a_r7_class_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(cur_ac));
  a_r7_txop_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> (txop_left <= $past(txop_left)));
  a_r8_end_when_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_done_i && (txop_left == '0)) |=> !busy);
endmodule

// File: tb/test_qos_access_engine.sv
`timescale 1ns/1ps
module test_qos_access_engine;
  localparam int TICK_W = 16, CW_W = 10, AIFSN_W = 4, DESC_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic medium_idle, tick;
  logic [TICK_W-1:0] slot_len, sifs_len;
  logic [4*AIFSN_W-1:0] aifsn;
  logic [CW_W-1:0] cw_min, cw_max;
  logic [4*TICK_W-1:0] txop_lim;
  logic enq_valid, tx_done, tx_ok;
  logic [2:0] enq_prio;
  logic [DESC_W-1:0] enq_desc;
  logic grant;
  logic [1:0] grant_ac;
  logic [DESC_W-1:0] grant_desc;
  logic [TICK_W-1:0] txop_left;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  qos_access_engine i_qos_access_engine (
    .clk_i(clk), .rst_ni(rst_ni), .medium_idle_i(medium_idle), .tick_i(tick),
    .slot_len_i(slot_len), .sifs_len_i(sifs_len), .aifsn_i(aifsn),
    .cw_min_i(cw_min), .cw_max_i(cw_max), .txop_lim_i(txop_lim),
    .enq_valid_i(enq_valid), .enq_prio_i(enq_prio), .enq_desc_i(enq_desc),
    .tx_done_i(tx_done), .tx_ok_i(tx_ok), .grant_o(grant), .grant_ac_o(grant_ac),
    .grant_desc_o(grant_desc), .txop_left_o(txop_left));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; medium_idle = 1'b0; tick = 1'b1;
    slot_len = 16'd1; sifs_len = 16'd2;
    aifsn = {4'd2, 4'd2, 4'd3, 4'd7};
    cw_min = '0; cw_max = '0; txop_lim = '0;
    enq_valid = 1'b0; enq_prio = '0; enq_desc = '0; tx_done = 1'b0; tx_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic enq(input logic [2:0] prio, input logic [DESC_W-1:0] d);
    enq_valid = 1'b1; enq_prio = prio; enq_desc = d;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    medium_idle = 1'b1;
    n = 0;
    while (n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (grant) break;
    end
  endtask

  task automatic pulse_done(input logic ok);
    tx_done = 1'b1; tx_ok = ok;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  function automatic int ref_ac(input int up);
    case (up)
      1, 2: return 0;
      0, 3: return 1;
      4, 5: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk("R7 reset grant", int'(grant), 0);
    chk("R7 reset txop_left", int'(txop_left), 0);
  endtask

  task automatic t_prio_map();
    int n;
    for (int up = 0; up < 8; up++) begin
      do_reset();
      enq(3'(up), 8'(8'h10 + up));
      repeat (3) @(negedge clk);
      measure(n);
      chk($sformatf("R1 class for priority %0d", up), int'(grant_ac), ref_ac(up));
    end
  endtask

  task automatic t_aifs();
    int n;
    do_reset(); slot_len = 16'd2; sifs_len = 16'd3;
    enq(3'd1, 8'hB1); repeat (3) @(negedge clk);
    measure(n);
    chk("R2 background idle wait 7*2+3", n, 18);
    do_reset(); slot_len = 16'd2; sifs_len = 16'd3;
    enq(3'd7, 8'hF7); repeat (3) @(negedge clk);
    measure(n);
    chk("R2 voice idle wait 2*2+3", n, 8);
    do_reset();
    enq(3'd0, 8'hE0); repeat (3) @(negedge clk);
    tick = 1'b0; medium_idle = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 no grant without ticks", int'(grant), 0);
    tick = 1'b1;
    measure(n);
    chk("R2 wait starts at first tick", n, 6);
  endtask

  task automatic t_busy_restart();
    int n;
    do_reset();
    enq(3'd2, 8'hB2); repeat (3) @(negedge clk);
    medium_idle = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 no grant in partial wait", int'(grant), 0);
    medium_idle = 1'b0;
    repeat (3) @(negedge clk);
    measure(n);
    chk("R3 idle wait restarts from zero", n, 10);
  endtask

  task automatic t_priority();
    int n;
    do_reset();
    enq(3'd5, 8'h55); enq(3'd7, 8'h77);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R4 simultaneous ready delay", n, 5);
    chk("R4 voice beats video", int'(grant_ac), 3);
    chk("R5 voice descriptor", int'(grant_desc), 'h77);
    medium_idle = 1'b0;
    pulse_done(1'b1);
    chk("R6 single exchange ends grant", int'(grant), 0);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R4 loser granted later", int'(grant_ac), 2);
    chk("R5 video descriptor kept", int'(grant_desc), 'h55);
  endtask

  task automatic t_txop_zero();
    int n;
    do_reset();
    enq(3'd0, 8'h01); enq(3'd3, 8'h02);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R5 first in first out", int'(grant_desc), 'h01);
    chk("R6 zero limit left", int'(txop_left), 0);
    medium_idle = 1'b0;
    repeat (2) @(negedge clk);
    pulse_done(1'b1);
    chk("R6 zero limit one exchange", int'(grant), 0);
  endtask

  task automatic t_txop_burst();
    int n;
    do_reset();
    txop_lim[63:48] = 16'd20;
    enq(3'd6, 8'h31); enq(3'd6, 8'h32); enq(3'd7, 8'h33);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R7 limit loaded", int'(txop_left), 20);
    chk("R5 burst head", int'(grant_desc), 'h31);
    medium_idle = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 countdown per tick", int'(txop_left), 17);
    pulse_done(1'b1);
    chk("R8 grant continues", int'(grant), 1);
    chk("R8 next frame shown", int'(grant_desc), 'h32);
    chk("R7 countdown across exchange", int'(txop_left), 16);
    pulse_done(1'b1);
    chk("R8 third frame shown", int'(grant_desc), 'h33);
    chk("R7 class held", int'(grant_ac), 3);
    pulse_done(1'b1);
    chk("R8 ends when queue empty", int'(grant), 0);
  endtask

  task automatic t_txop_expire();
    int n;
    do_reset();
    txop_lim[63:48] = 16'd4;
    enq(3'd7, 8'h41); enq(3'd7, 8'h42);
    repeat (3) @(negedge clk);
    measure(n);
    medium_idle = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 countdown stops at zero", int'(txop_left), 0);
    chk("R7 grant held during exchange", int'(grant), 1);
    pulse_done(1'b1);
    chk("R8 expired limit ends grant", int'(grant), 0);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R8 remaining frame contends again", int'(grant_desc), 'h42);
  endtask

  task automatic t_failure();
    int n;
    do_reset(); cw_max = 10'd3;
    enq(3'd3, 8'hA1); enq(3'd3, 8'hB2);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R9 first attempt delay", n, 6);
    medium_idle = 1'b0;
    pulse_done(1'b0);
    chk("R9 failure ends grant", int'(grant), 0);
    repeat (3) @(negedge clk);
    measure(n);
    chk_rng("R9 retry within window 1", n, 6, 7);
    chk("R9 failed frame kept", int'(grant_desc), 'hA1);
    medium_idle = 1'b0;
    pulse_done(1'b1);
    repeat (3) @(negedge clk);
    measure(n);
    chk("R10 window back to minimum", n, 6);
    chk("R5 second frame after success", int'(grant_desc), 'hB2);
    do_reset(); cw_max = 10'd3;
    enq(3'd0, 8'hC3);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      measure(n);
      chk_rng("R9 window capped at max", n, 6, 9);
      medium_idle = 1'b0;
      pulse_done(1'b0);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_derived_windows();
    int n;
    do_reset(); cw_min = 10'd3; cw_max = 10'd15;
    enq(3'd6, 8'h66); repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      measure(n);
      if (i == 0) chk("R11 voice minimum window zero", n, 5);
      else chk_rng("R11 voice window capped at 1", n, 5, 6);
      medium_idle = 1'b0;
      pulse_done(1'b0);
      repeat (3) @(negedge clk);
    end
    do_reset(); cw_min = 10'd3; cw_max = 10'd15;
    enq(3'd4, 8'h44); repeat (3) @(negedge clk);
    measure(n);
    chk_rng("R11 video minimum window 1", n, 5, 6);
    do_reset(); cw_min = 10'd3; cw_max = 10'd15;
    enq(3'd1, 8'h11); repeat (3) @(negedge clk);
    measure(n);
    chk_rng("R11 background base window 3", n, 10, 13);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset_state();
    t_prio_map();
    t_aifs();
    t_busy_restart();
    t_priority();
    t_txop_zero();
    t_txop_burst();
    t_txop_expire();
    t_failure();
    t_derived_windows();
    finish_run();
  end
endmodule